// File: doc/BRIEF.md
# PWM Timer Tick Prescaler Tree

This block turns one system clock into count-enable ticks for five timer channels. Two shared 8-bit prescalers feed the channels unevenly: prescaler A serves channels 0 and 1, and prescaler B serves channels 2, 3 and 4. Behind its prescaler, each channel has a private power-of-two divider. A per-channel code can also replace the divided tick with pulses taken from an external timer clock. External clock 0 feeds channels 0 and 1, and external clock 1 feeds channels 2 to 4.

Software programs the block through a small register port. Register 0 holds both prescaler settings. Register 1 holds one 4-bit source code per channel, so a single write chooses both the divide and the source. Each output is a pulse one system clock wide, and the timer counters use it as a count enable. The whole block runs in the system clock domain.

Each channel's source code selects one of five modes. The modes are divide-by-2, divide-by-4, divide-by-8, divide-by-16 and external. Each prescaler runs a count-down loop. It is at terminal count when the count is zero and is counting otherwise. At terminal count it emits a pulse and reloads. When counting it decrements.

Top module: `pwm_tick_tree`

## Requirements
- R1: After reset, both configuration registers read zero. Every channel then ticks once every 2 system clocks.
- R2: A write with `cfg_addr`=0 or 1 stores all 32 bits of `cfg_wdata` into register 0 or register 1. `cfg_rdata` returns the register selected by `cfg_addr` unchanged.
- R3: Prescaler A takes its setting s from register 0 bits [7:0], and prescaler B takes its setting from bits [15:8]. Each prescaler pulses once every s+1 system clocks, for s from 0 to 255. Channels 0 and 1 use prescaler A, and channels 2 to 4 use prescaler B.
- R4: Channel c's code sits in register 1 bits [4c+3:4c]. Codes 0 to 3 give one tick every 2^(code+1) prescaler pulses, so the tick period is (s+1)·2^(code+1) clocks.
- R5: Code 4 makes the channel tick once for each rising edge of its external clock, after a two-flop synchronizer. Channels 0 and 1 use `ext_clk[0]`, and channels 2 to 4 use `ext_clk[1]`. Divided ticks are suppressed in this mode.
- R6: Codes 5 to 15 behave exactly like code 3 (divide by 16).
- R7: Every tick output is high for exactly one system clock at a time.
- R8: A new prescaler setting is loaded only at that prescaler's terminal count. The prescale interval already in progress completes with the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 = prescalers, 1 = channel codes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| ext_clk | input | 2 | External timer clocks, asynchronous |
| tick_o | output | 5 | One-cycle count-enable pulse per channel |

## Verification
The bench measures the steady tick period of every channel under random prescaler settings and codes. It also pushes the largest setting, which gives a 4096-clock period. A swapped prescaler assignment or a wrong field offset shows up as a wrong period on the affected channel. Codes 5 to 15 are exercised directly, because a design that treats them as external or as divide-by-2 gives a tick period that is zero or far too short. The bench counts external-clock ticks on the channels that select each external clock. A design that keeps emitting divided ticks in external mode, or that routes the wrong external clock, gets the wrong count. Finally, a prescaler setting is changed in the middle of a long interval. A design that reloads at once, instead of at terminal count, shortens the gap well below the expected 205 clocks.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;

    localparam int CODE_W = 4;
    localparam int CNT_W  = 4;

    // Channel source modes decoded from a 4-bit code
    typedef enum logic [2:0] {
        SRC_DIV2  = 3'd0,
        SRC_DIV4  = 3'd1,
        SRC_DIV8  = 3'd2,
        SRC_DIV16 = 3'd3,
        SRC_EXT   = 3'd4
    } src_sel_e;

    // Prescaler loop phases
    typedef enum logic {
        PS_TERM  = 1'b0,
        PS_COUNT = 1'b1
    } ps_phase_e;

    localparam logic [CODE_W-1:0] CODE_EXT = 4'd4;

    function automatic src_sel_e decode_code(input logic [CODE_W-1:0] code);
        if (code < CODE_EXT)
            return src_sel_e'({1'b0, code[1:0]});
        else if (code == CODE_EXT)
            return SRC_EXT;
        else
            return SRC_DIV16;
    endfunction

    function automatic logic [CNT_W-1:0] div_mask(input src_sel_e s);
        logic [CNT_W-1:0] m;
        case (s)
            SRC_DIV2: m = 4'b0001;
            SRC_DIV4: m = 4'b0011;
            SRC_DIV8: m = 4'b0111;
            default:  m = 4'b1111;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_tick_pkg::*;
#(
    parameter int PS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PS_W-1:0] set_i,
    output logic            pulse_o,
    output logic [PS_W-1:0] cnt_o
);

    logic [PS_W-1:0] cnt_q;
    ps_phase_e       phase;

    assign phase = (cnt_q == '0) ? PS_TERM : PS_COUNT;

    // State register: the setting is sampled only at terminal count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (phase)
                PS_TERM:  cnt_q <= set_i;
                PS_COUNT: cnt_q <= cnt_q - PS_W'(1);
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (phase)
            PS_TERM:  pulse_o = 1'b1;
            PS_COUNT: pulse_o = 1'b0;
        endcase
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/pwm_ext_edge.sv
module pwm_ext_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_i,
    output logic rise_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], ext_i};
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign rise_o = sync_q[SYNC_STAGES-1] & ~last_q;

endmodule

// File: rtl/pwm_chan_div.sv
module pwm_chan_div
    import pwm_tick_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_i,
    input  logic              pre_pulse_i,
    input  logic              ext_rise_i,
    output logic              tick_o
);

    src_sel_e         sel;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask;

    assign sel  = decode_code(code_i);
    assign mask = div_mask(sel);

    // Free-running count of prescaler pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (pre_pulse_i)
            cnt_q <= cnt_q + CNT_W'(1);
    end

    // Output select per mode
    always_comb begin
        unique case (sel)
            SRC_EXT:
                tick_o = ext_rise_i;
            SRC_DIV2, SRC_DIV4, SRC_DIV8, SRC_DIV16:
                tick_o = pre_pulse_i && ((cnt_q & mask) == mask);
            default:
                tick_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pwm_tick_tree.sv
module pwm_tick_tree
    import pwm_tick_pkg::*;
#(
    parameter int NCH         = 5,
    parameter int SPLIT       = 2,
    parameter int PS_W        = 8,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic [1:0]        ext_clk,
    output logic [NCH-1:0]    tick_o
);

    localparam int NPS = 2;

    logic [DATA_W-1:0]         cfg0_q;
    logic [DATA_W-1:0]         cfg1_q;
    logic [NPS-1:0]            pre_pulse;
    logic [NPS-1:0][PS_W-1:0]  pre_cnt;
    logic [NPS-1:0]            ext_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg0_q <= '0;
            cfg1_q <= '0;
        end else if (cfg_we) begin
            if (cfg_addr) cfg1_q <= cfg_wdata;
            else          cfg0_q <= cfg_wdata;
        end
    end

    assign cfg_rdata = cfg_addr ? cfg1_q : cfg0_q;

    for (genvar g = 0; g < NPS; g++) begin : g_grp
        pwm_prescaler #(.PS_W(PS_W)) u_ps (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (cfg0_q[g*PS_W +: PS_W]),
            .pulse_o (pre_pulse[g]),
            .cnt_o   (pre_cnt[g])
        );
        pwm_ext_edge #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
            .clk    (clk),
            .rst_n  (rst_n),
            .ext_i  (ext_clk[g]),
            .rise_o (ext_rise[g])
        );
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int GRP = (c < SPLIT) ? 0 : 1;
        pwm_chan_div u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .code_i      (cfg1_q[c*CODE_W +: CODE_W]),
            .pre_pulse_i (pre_pulse[GRP]),
            .ext_rise_i  (ext_rise[GRP]),
            .tick_o      (tick_o[c])
        );
    end

endmodule

// File: rtl/pwm_tick_tree_chk.sv
module pwm_tick_tree_chk
    import pwm_tick_pkg::*;
#(
    parameter int NCH    = 5,
    parameter int SPLIT  = 2,
    parameter int PS_W   = 8,
    parameter int DATA_W = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cfg_we,
    input logic                   cfg_addr,
    input logic [DATA_W-1:0]      cfg_wdata,
    input logic [DATA_W-1:0]      cfg0_q,
    input logic [DATA_W-1:0]      cfg1_q,
    input logic [1:0][PS_W-1:0]   pre_cnt,
    input logic [1:0]             pre_pulse,
    input logic [1:0]             ext_rise,
    input logic [NCH-1:0]         tick_o
);

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg0_q == '0 && cfg1_q == '0));

    // R2
    wr_cfg0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_addr) |=> cfg0_q == $past(cfg_wdata));

    // R2
    wr_cfg1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr) |=> cfg1_q == $past(cfg_wdata));

    for (genvar g = 0; g < 2; g++) begin : g_ps
        // R8
        pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pre_cnt[g] != '0) |=> pre_cnt[g] == $past(pre_cnt[g]) - PS_W'(1));
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int GRP = (c < SPLIT) ? 0 : 1;
        // R7
        one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tick_o[c] |=> !tick_o[c]);
        // R5
        ext_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg1_q[c*4 +: 4] == 4'd4 && !ext_rise[GRP]) |-> !tick_o[c]);
        // R4
        div_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg1_q[c*4 +: 4] != 4'd4 && tick_o[c]) |-> pre_pulse[GRP]);
    end

endmodule

bind pwm_tick_tree pwm_tick_tree_chk #(
    .NCH(NCH), .SPLIT(SPLIT), .PS_W(PS_W), .DATA_W(DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg0_q    (cfg0_q),
    .cfg1_q    (cfg1_q),
    .pre_cnt   (pre_cnt),
    .pre_pulse (pre_pulse),
    .ext_rise  (ext_rise),
    .tick_o    (tick_o)
);

// File: tb/pwm_tick_tree_bench.sv
`timescale 1ns/1ps
module pwm_tick_tree_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_addr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [1:0]  ext_clk = 2'b00;
    logic [4:0]  tick_o;

    int total = 0;
    int bad = 0;
    int ecnt [5];
    logic counting = 1'b0;

    always #10 clk = ~clk;

    pwm_tick_tree u_pwm_tick_tree (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ext_clk(ext_clk),
        .tick_o(tick_o)
    );

    always @(negedge clk)
        if (counting)
            for (int i = 0; i < 5; i++) ecnt[i] += int'(tick_o[i]);

    function automatic int exp_gap(input int s, input int code);
        int n;
        n = (code > 3) ? 3 : code;
        return (s + 1) * (2 << n);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input bit a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input bit a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic next_gap(input int ch, output int g);
        g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!tick_o[ch] && g < 20000);
    endtask

    task automatic period(input int ch, output int g);
        int d;
        next_gap(ch, d);
        next_gap(ch, d);
        next_gap(ch, g);
    endtask

    task automatic check_chan(input int ch, input int s, input int code, input string req);
        int g, e;
        e = exp_gap(s, code);
        period(ch, g);
        check(g == e, req, g, e);
    endtask

    task automatic pulse_ext(input int idx, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); ext_clk[idx] = 1'b1;
            repeat ($urandom_range(1, 4)) @(negedge clk);
            ext_clk[idx] = 1'b0;
            repeat ($urandom_range(1, 4)) @(negedge clk);
        end
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int s0, s1, g, n;
        int codes [5];
        logic [31:0] w;
        void'($urandom(32'd2024));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(1'b0, r); check(r == 0, "R1 cfg0 reset", int'(r), 0);
        rd(1'b1, r); check(r == 0, "R1 cfg1 reset", int'(r), 0);
        check_chan(0, 0, 0, "R1 ch0 reset period");
        check_chan(4, 0, 0, "R1 ch4 reset period");

        // R2 full readback
        wr(1'b0, 32'hA5C3_0000); rd(1'b0, r);
        check(r == 32'hA5C3_0000, "R2 cfg0 readback", int'(r), int'(32'hA5C3_0000));
        wr(1'b1, 32'h5A00_0000); rd(1'b1, r);
        check(r == 32'h5A00_0000, "R2 cfg1 readback", int'(r), int'(32'h5A00_0000));

        // R3 distinct prescalers, group split
        wr(1'b0, 32'h0000_0205); wr(1'b1, 32'h0);
        check_chan(0, 5, 0, "R3 ch0 uses prescaler A");
        check_chan(1, 5, 0, "R3 ch1 uses prescaler A");
        check_chan(2, 2, 0, "R3 ch2 uses prescaler B");
        check_chan(3, 2, 0, "R3 ch3 uses prescaler B");

        // R4 R6 largest setting and aliased codes
        wr(1'b0, 32'h0000_FFFF); wr(1'b1, 32'h0001_F093);
        check_chan(0, 255, 3, "R4 ch0 code3 max");
        check_chan(1, 255, 9, "R6 ch1 code9");
        check_chan(2, 255, 0, "R4 ch2 code0");
        check_chan(3, 255, 15, "R6 ch3 code15");
        check_chan(4, 255, 1, "R4 ch4 code1");

        // R4 R6 random settings and codes
        for (int it = 0; it < 8; it++) begin
            s0 = $urandom_range(0, 12);
            s1 = $urandom_range(0, 12);
            w = '0;
            for (int c = 0; c < 5; c++) begin
                codes[c] = $urandom_range(0, 14);
                if (codes[c] >= 4) codes[c] = codes[c] + 1;
                w[c*4 +: 4] = 4'(codes[c]);
            end
            wr(1'b0, {16'h0, 8'(s1), 8'(s0)});
            wr(1'b1, w);
            for (int c = 0; c < 5; c++)
                check_chan(c, (c < 2) ? s0 : s1, codes[c], "R4 random period");
        end

        // R5 external clocks
        wr(1'b0, 32'h0000_0101); wr(1'b1, 32'h0000_4404);
        for (int i = 0; i < 5; i++) ecnt[i] = 0;
        repeat (10) @(negedge clk);
        counting = 1'b1;
        pulse_ext(0, 5);
        counting = 1'b0;
        check(ecnt[0] == 5, "R5 ch0 ext0 edges", ecnt[0], 5);
        check(ecnt[2] == 0, "R5 ch2 ignores ext0", ecnt[2], 0);
        check(ecnt[3] == 0, "R5 ch3 no divided ticks", ecnt[3], 0);
        for (int i = 0; i < 5; i++) ecnt[i] = 0;
        counting = 1'b1;
        pulse_ext(1, 7);
        counting = 1'b0;
        check(ecnt[2] == 7, "R5 ch2 ext1 edges", ecnt[2], 7);
        check(ecnt[3] == 7, "R5 ch3 ext1 edges", ecnt[3], 7);
        check(ecnt[0] == 0, "R5 ch0 ignores ext1", ecnt[0], 0);

        // R7 single-cycle width at fastest rate
        wr(1'b0, 32'h0); wr(1'b1, 32'h0);
        n = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (tick_o[0]) begin
                @(negedge clk);
                if (tick_o[0]) n++;
            end
        end
        check(n == 0, "R7 tick width one cycle", n, 0);

        // R8 reload only at terminal count
        wr(1'b0, 32'h0000_00C8); wr(1'b1, 32'h0);
        period(0, g);
        check(g == 402, "R8 old period", g, 402);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 20) begin
                cfg_we = 1'b1; cfg_addr = 1'b0; cfg_wdata = 32'h3;
            end
            if (n == 21) cfg_we = 1'b0;
        end while (!tick_o[0] && n < 20000);
        check(n == 205, "R8 interval finishes with old setting", n, 205);
        check_chan(0, 3, 0, "R8 new period");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule